// File: doc/BRIEF.md
# Interleaved Page Column Mapper

This block translates a position in one of four logical byte streams of a raw flash page into the physical column where that byte lives. The page is a main area followed by a spare area. Physically, each correction step stores its data chunk and then that chunk's check bytes, one step after another. A run of marker bytes is reserved at the very start of the spare area. Any chunk whose bytes would land on that reserved run is moved past it, so a chunk that straddles the end of the main area is cut in two. The free spare bytes fill the tail of the page.

The geometry comes in on plain, quasi-static configuration pins. These pins must not change while requests are in flight. Requests enter and results leave over valid/ready streams, and every request gives exactly one result, in order.

The pipeline is three registers deep and stalls as a whole:
- `in_ready` equals `!out_valid || out_ready`.
- A result held against a low `out_ready` stays stable, and no new request is taken.
- With `out_ready` high, one request is accepted per cycle.

Top module: `pcm_col_mapper`

## Requirements
- R1: Stream select 0 (data): index j maps to raw = (j / S)·(S+E) + (j mod S). Here S is the step size and E the check bytes per step. The column is raw + K when raw ≥ M and raw otherwise, where M is the main size and K the marker length.
- R2: Stream select 2 (check bytes): index j maps to raw = S + (j / E)·(S+E) + (j mod E), with the same adjustment by K at M.
- R3: A data or check chunk that starts below M and ends past it keeps its bytes below M in place. Its remaining bytes continue from column M+K. No data or check byte ever maps into [M, M+K).
- R4: Stream select 1 (marker): index j maps to column M + j.
- R5: Stream select 3 (free): index j maps to column M + P − F + j. Here P is the spare size and F = P − K − N·E, with N the step count.
- R6: An index at or above its stream's length sets `out_oor` and gives column 0. The lengths are N·S (data), K (marker), N·E (check) and F (free).
- R7: A marker length of 0 on `cfg_skip` selects the default marker length DEFAULT_SKIP (8).
- R8: With `cfg_pair` high, M, P, S, E and K (after R7) are all doubled before mapping. N is not doubled.
- R9: A request accepted at a clock edge appears on the outputs after the second following edge, and not earlier. With `out_ready` high, back-to-back requests emerge on consecutive cycles in order.
- R10: While `out_valid` is high and `out_ready` is low, `out_col`, `out_oor` and `out_valid` hold and `in_ready` is low.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_main | input | 16 | Main area size M in bytes |
| cfg_spare | input | 16 | Spare area size P in bytes |
| cfg_step | input | 16 | Data bytes per step S |
| cfg_ecc | input | 16 | Check bytes per step E |
| cfg_steps | input | 5 | Step count N (up to MAX_STEPS) |
| cfg_skip | input | 16 | Marker length K; 0 selects the default |
| cfg_pair | input | 1 | Two byte-wide devices side by side: double the geometry |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_sel | input | 2 | Stream: 0 data, 1 marker, 2 check, 3 free |
| in_index | input | 16 | Byte index within the stream |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer ready |
| out_col | output | 21 | Physical column |
| out_oor | output | 1 | Index was out of range for its stream |

## Verification
A wrong quotient in the step divider sends a whole chunk to another step's slot. The column jumps by a multiple of S+E at the port three cycles after the request. An off-by-one in the boundary compare shows only at the single index that lands on M, so the bench probes the bytes on each side of the split. A stall bug shows as a changed or lost result in the cycle right after `out_ready` drops, and reordering shows in the back-to-back sequence.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    STR_DATA = 2'd0,
    STR_MARK = 2'd1,
    STR_ECC  = 2'd2,
    STR_FREE = 2'd3
  } stream_e;
endpackage

// File: rtl/pcm_geometry.sv
// Effective page geometry after default-marker and paired-device adjustment,
// plus the length of every logical stream.
module pcm_geometry #(
  parameter int COL_W        = 16,
  parameter int CNT_W        = 5,
  parameter int DEFAULT_SKIP = 8,
  localparam int LW          = COL_W + CNT_W
) (
  input  logic [COL_W-1:0] cfg_main,
  input  logic [COL_W-1:0] cfg_spare,
  input  logic [COL_W-1:0] cfg_step,
  input  logic [COL_W-1:0] cfg_ecc,
  input  logic [CNT_W-1:0] cfg_steps,
  input  logic [COL_W-1:0] cfg_skip,
  input  logic             cfg_pair,
  output logic [LW-1:0]    g_main,
  output logic [LW-1:0]    g_step,
  output logic [LW-1:0]    g_ecc,
  output logic [LW-1:0]    g_skip,
  output logic [LW-1:0]    g_unit,
  output logic [LW-1:0]    len_data,
  output logic [LW-1:0]    len_ecc,
  output logic [LW-1:0]    len_free,
  output logic [LW-1:0]    free_base
);
  logic [LW-1:0] spare_w;
  logic [LW-1:0] skip_raw;
  logic [LW-1:0] gsp;

  always_comb begin
    spare_w  = LW'(cfg_spare);
    skip_raw = (cfg_skip == '0) ? LW'(DEFAULT_SKIP) : LW'(cfg_skip);
    if (cfg_pair) begin
      g_main = LW'(cfg_main) << 1;
      gsp    = spare_w << 1;
      g_step = LW'(cfg_step) << 1;
      g_ecc  = LW'(cfg_ecc) << 1;
      g_skip = skip_raw << 1;
    end else begin
      g_main = LW'(cfg_main);
      gsp    = spare_w;
      g_step = LW'(cfg_step);
      g_ecc  = LW'(cfg_ecc);
      g_skip = skip_raw;
    end
    g_unit    = g_step + g_ecc;
    len_data  = g_step * LW'(cfg_steps);
    len_ecc   = g_ecc * LW'(cfg_steps);
    len_free  = gsp - g_skip - len_ecc;
    free_base = g_main + gsp - len_free;
  end
endmodule

// File: rtl/pcm_divider.sv
// Single-cycle division of an index by a run length for quotients below
// MAX_STEPS, using a bank of parallel threshold compares.
module pcm_divider #(
  parameter int LW        = 21,
  parameter int MAX_STEPS = 16,
  parameter int CNT_W     = 5
) (
  input  logic [LW-1:0]    idx,
  input  logic [LW-1:0]    len,
  output logic [CNT_W-1:0] quot,
  output logic [LW-1:0]    rem
);
  logic [LW-1:0]        thr [MAX_STEPS];
  logic [MAX_STEPS-1:0] hit;

  assign thr[0] = '0;
  assign hit[0] = 1'b0;

  for (genvar k = 1; k < MAX_STEPS; k++) begin : g_thr
    assign thr[k] = len * LW'(k);
    assign hit[k] = (idx >= thr[k]);
  end

  always_comb begin
    logic [LW-1:0] base;
    quot = '0;
    base = '0;
    for (int k = 1; k < MAX_STEPS; k++) begin
      if (hit[k]) begin
        quot = quot + CNT_W'(1);
        base = thr[k];
      end
    end
    rem = idx - base;
  end
endmodule

// File: rtl/pcm_place.sv
// Turns a (step, offset) pair or a direct stream offset into a column.
module pcm_place
  import pcm_pkg::*;
#(
  parameter int LW    = 21,
  parameter int CNT_W = 5
) (
  input  stream_e          sel,
  input  logic [CNT_W-1:0] step_q,
  input  logic [LW-1:0]    off,
  input  logic [LW-1:0]    g_main,
  input  logic [LW-1:0]    g_step,
  input  logic [LW-1:0]    g_skip,
  input  logic [LW-1:0]    g_unit,
  input  logic [LW-1:0]    free_base,
  output logic [LW-1:0]    col
);
  logic [LW-1:0] raw;

  always_comb begin
    raw = ((sel == STR_ECC) ? g_step : '0) + LW'(step_q) * g_unit + off;
    unique case (sel)
      STR_MARK: col = g_main + off;
      STR_FREE: col = free_base + off;
      default:  col = (raw >= g_main) ? raw + g_skip : raw;
    endcase
  end
endmodule

// File: rtl/pcm_col_mapper.sv
module pcm_col_mapper
  import pcm_pkg::*;
#(
  parameter int COL_W        = 16,
  parameter int MAX_STEPS    = 16,
  parameter int DEFAULT_SKIP = 8,
  localparam int CNT_W       = $clog2(MAX_STEPS + 1),
  localparam int LW          = COL_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] cfg_main,
  input  logic [COL_W-1:0] cfg_spare,
  input  logic [COL_W-1:0] cfg_step,
  input  logic [COL_W-1:0] cfg_ecc,
  input  logic [CNT_W-1:0] cfg_steps,
  input  logic [COL_W-1:0] cfg_skip,
  input  logic             cfg_pair,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_sel,
  input  logic [COL_W-1:0] in_index,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LW-1:0]    out_col,
  output logic             out_oor
);
  logic [LW-1:0] g_main, g_step, g_ecc, g_skip, g_unit;
  logic [LW-1:0] len_data, len_ecc, len_free, free_base;

  pcm_geometry #(.COL_W(COL_W), .CNT_W(CNT_W), .DEFAULT_SKIP(DEFAULT_SKIP)) u_geom (
    .cfg_main(cfg_main), .cfg_spare(cfg_spare), .cfg_step(cfg_step),
    .cfg_ecc(cfg_ecc), .cfg_steps(cfg_steps), .cfg_skip(cfg_skip),
    .cfg_pair(cfg_pair),
    .g_main(g_main), .g_step(g_step), .g_ecc(g_ecc), .g_skip(g_skip),
    .g_unit(g_unit), .len_data(len_data), .len_ecc(len_ecc),
    .len_free(len_free), .free_base(free_base)
  );

  // Whole-pipe advance: every stage moves together or not at all.
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage 1: capture request and range check.
  stream_e       in_str;
  logic [LW-1:0] in_idx_w;
  logic          in_oor;
  assign in_str   = stream_e'(in_sel);
  assign in_idx_w = LW'(in_index);

  always_comb begin
    unique case (in_str)
      STR_DATA: in_oor = (in_idx_w >= len_data);
      STR_MARK: in_oor = (in_idx_w >= g_skip);
      STR_ECC:  in_oor = (in_idx_w >= len_ecc);
      default:  in_oor = (in_idx_w >= len_free);
    endcase
  end

  logic          s1_v, s1_oor;
  stream_e       s1_sel;
  logic [LW-1:0] s1_idx;

  // Stage 2: split the index into step number and offset.
  logic [CNT_W-1:0] div_q;
  logic [LW-1:0]    div_r;
  logic [LW-1:0]    s1_len;
  assign s1_len = (s1_sel == STR_ECC) ? g_ecc : g_step;

  pcm_divider #(.LW(LW), .MAX_STEPS(MAX_STEPS), .CNT_W(CNT_W)) u_div (
    .idx(s1_idx), .len(s1_len), .quot(div_q), .rem(div_r)
  );

  logic             s2_v, s2_oor;
  stream_e          s2_sel;
  logic [CNT_W-1:0] s2_q;
  logic [LW-1:0]    s2_off;

  // Stage 3: place in the physical page.
  logic [LW-1:0] place_col;
  pcm_place #(.LW(LW), .CNT_W(CNT_W)) u_place (
    .sel(s2_sel), .step_q(s2_q), .off(s2_off), .g_main(g_main),
    .g_step(g_step), .g_skip(g_skip), .g_unit(g_unit),
    .free_base(free_base), .col(place_col)
  );

  stream_e o_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      out_valid <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_sel <= in_str;
      s1_idx <= in_idx_w;
      s1_oor <= in_oor;
      s2_sel <= s1_sel;
      s2_oor <= s1_oor;
      if (s1_sel == STR_DATA || s1_sel == STR_ECC) begin
        s2_q   <= div_q;
        s2_off <= div_r;
      end else begin
        s2_q   <= '0;
        s2_off <= s1_idx;
      end
      o_sel   <= s2_sel;
      out_oor <= s2_oor;
      out_col <= s2_oor ? '0 : place_col;
    end
  end

  // R10: a stalled result is held unchanged.
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_col) && $stable(out_oor));

  // R10: no acceptance while stalled.
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R6: out-of-range results carry column zero.
  a_r6_zero_col: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_oor |-> out_col == '0);

  // R3: data and check bytes never land on the marker run.
  a_r3_skip_hole: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_oor && (o_sel == STR_DATA || o_sel == STR_ECC)
    |-> !(out_col >= g_main && out_col < g_main + g_skip));

  // R1: divider remainder of an in-range data index stays inside one step.
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && !s1_oor && s1_sel == STR_DATA |-> div_r < g_step);

  // R9: an accepted request enters the first stage on the next edge.
  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_v);
endmodule

// File: tb/pcm_col_mapper_tb.sv
module pcm_col_mapper_tb;
  localparam int COL_W = 16;
  localparam int CNT_W = 5;
  localparam int LW    = COL_W + CNT_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [COL_W-1:0] cfg_main, cfg_spare, cfg_step, cfg_ecc, cfg_skip;
  logic [CNT_W-1:0] cfg_steps;
  logic             cfg_pair;
  logic             in_valid, in_ready, out_valid, out_ready, out_oor;
  logic [1:0]       in_sel;
  logic [COL_W-1:0] in_index;
  logic [LW-1:0]    out_col;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  pcm_col_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_main(cfg_main), .cfg_spare(cfg_spare),
    .cfg_step(cfg_step), .cfg_ecc(cfg_ecc), .cfg_steps(cfg_steps),
    .cfg_skip(cfg_skip), .cfg_pair(cfg_pair), .in_valid(in_valid),
    .in_ready(in_ready), .in_sel(in_sel), .in_index(in_index),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col),
    .out_oor(out_oor)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int m, s, st, ec, n, k, input bit p);
    cfg_main = COL_W'(m); cfg_spare = COL_W'(s); cfg_step = COL_W'(st);
    cfg_ecc = COL_W'(ec); cfg_steps = CNT_W'(n); cfg_skip = COL_W'(k);
    cfg_pair = p;
  endtask

  // Independent model of the mapping rules.
  task automatic model(input int sel, idx, output longint col, output bit oor);
    longint m, s, st, ec, n, k, f, raw, len;
    m = cfg_main; s = cfg_spare; st = cfg_step; ec = cfg_ecc;
    n = cfg_steps; k = cfg_skip;
    if (k == 0) k = 8;                        // R7
    if (cfg_pair) begin                       // R8
      m *= 2; s *= 2; st *= 2; ec *= 2; k *= 2;
    end
    f = s - k - n * ec;
    case (sel)
      0: len = n * st;
      1: len = k;
      2: len = n * ec;
      default: len = f;
    endcase
    oor = (idx >= len);
    col = 0;
    if (!oor) begin
      case (sel)
        0: raw = (idx / st) * (st + ec) + idx % st;
        2: raw = st + (idx / ec) * (st + ec) + idx % ec;
        default: raw = 0;
      endcase
      if (sel == 1) col = m + idx;
      else if (sel == 3) col = m + s - f + idx;
      else col = (raw >= m) ? raw + k : raw;
    end
  endtask

  // One isolated request; checks the latency (R9) on the way.
  task automatic send_one(input int sel, idx, output longint col, output bit oor);
    @(negedge clk);
    in_valid = 1'b1; in_sel = 2'(sel); in_index = COL_W'(idx);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 not early", longint'(out_valid), 0);
    @(negedge clk);
    check("R9 valid on time", longint'(out_valid), 1);
    col = longint'(out_col);
    oor = out_oor;
  endtask

  task automatic expect_col(input string req, input int sel, idx, input longint exp_col);
    longint c, mc; bit o, mo;
    send_one(sel, idx, c, o);
    model(sel, idx, mc, mo);
    check(req, c, exp_col);
    check(req, c, mc);
    check(req, longint'(o), longint'(mo));
  endtask

  task automatic base_cfg();
    set_cfg(96, 40, 24, 6, 4, 8, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_sel = '0; in_index = '0;
    base_cfg();
    repeat (3) @(negedge clk);
    check("R11 out_valid in reset", longint'(out_valid), 0);
    check("R11 in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", longint'(out_valid), 0);
  endtask

  task automatic t_data();
    base_cfg();
    expect_col("R1 data j0", 0, 0, 0);
    expect_col("R1 data j25", 0, 25, 31);
    expect_col("R1 data j50", 0, 50, 62);
    for (int j = 0; j < 96; j += 7) begin
      longint c, mc; bit o, mo;
      send_one(0, j, c, o);
      model(0, j, mc, mo);
      check("R1 data sweep", c, mc);
    end
  endtask

  task automatic t_ecc();
    base_cfg();
    expect_col("R2 ecc j0", 2, 0, 24);
    expect_col("R2 ecc j7", 2, 7, 55);
    expect_col("R2 ecc j18", 2, 18, 122);
    expect_col("R2 ecc j23", 2, 23, 127);
  endtask

  task automatic t_cross();
    base_cfg();
    expect_col("R3 last byte below main", 0, 77, 95);
    expect_col("R3 first byte past marker", 0, 78, 104);
    expect_col("R3 last byte of split chunk", 0, 95, 121);
  endtask

  task automatic t_marker();
    base_cfg();
    expect_col("R4 marker j0", 1, 0, 96);
    expect_col("R4 marker j7", 1, 7, 103);
  endtask

  task automatic t_free();
    base_cfg();
    expect_col("R5 free j0", 3, 0, 128);
    expect_col("R5 free j7", 3, 7, 135);
  endtask

  task automatic t_oor();
    longint c; bit o;
    base_cfg();
    send_one(0, 96, c, o); check("R6 data oor flag", longint'(o), 1); check("R6 data oor col", c, 0);
    send_one(2, 24, c, o); check("R6 ecc oor flag", longint'(o), 1);
    send_one(1, 8, c, o);  check("R6 marker oor flag", longint'(o), 1);
    send_one(3, 8, c, o);  check("R6 free oor flag", longint'(o), 1); check("R6 free oor col", c, 0);
    send_one(3, 7, c, o);  check("R6 free last in range", longint'(o), 0);
  endtask

  task automatic t_skip();
    longint c; bit o;
    set_cfg(96, 40, 24, 6, 4, 4, 1'b0);
    expect_col("R7 explicit skip marker", 1, 3, 99);
    expect_col("R7 explicit skip data", 0, 78, 100);
    expect_col("R7 explicit skip free", 3, 0, 124);
    send_one(1, 4, c, o); check("R7 explicit skip oor", longint'(o), 1);
    set_cfg(96, 40, 24, 6, 4, 0, 1'b0);
    expect_col("R7 default skip marker", 1, 7, 103);
    send_one(1, 8, c, o); check("R7 default skip oor", longint'(o), 1);
  endtask

  task automatic t_pair();
    set_cfg(96, 40, 24, 6, 4, 8, 1'b1);
    expect_col("R8 pair data split", 0, 160, 212);
    expect_col("R8 pair ecc j0", 2, 0, 48);
    expect_col("R8 pair marker", 1, 15, 207);
    expect_col("R8 pair free", 3, 0, 256);
  endtask

  task automatic t_stream();
    int sels[4] = '{0, 2, 1, 3};
    int idxs[4] = '{0, 7, 1, 2};
    longint exp[4] = '{0, 55, 97, 130};
    base_cfg();
    out_ready = 1'b1;
    for (int t = 0; t < 7; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        check("R9 stream valid", longint'(out_valid), 1);
        check("R9 stream order", longint'(out_col), exp[t-3]);
      end
      if (t < 4) begin
        in_valid = 1'b1; in_sel = 2'(sels[t]); in_index = COL_W'(idxs[t]);
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    check("R9 stream drained", longint'(out_valid), 0);
  endtask

  task automatic t_backpressure();
    base_cfg();
    out_ready = 1'b0;
    @(negedge clk); in_valid = 1'b1; in_sel = 2'd0; in_index = 16'd1;   // A -> 1
    @(negedge clk); in_sel = 2'd2; in_index = 16'd1;                     // B -> 25
    @(negedge clk); in_sel = 2'd1; in_index = 16'd0;                     // C -> 96
    @(negedge clk);
    check("R10 stalled valid", longint'(out_valid), 1);
    check("R10 in_ready low", longint'(in_ready), 0);
    check("R10 first result", longint'(out_col), 1);
    in_sel = 2'd3; in_index = 16'd0;                                     // D -> 128
    @(negedge clk);
    check("R10 held col", longint'(out_col), 1);
    check("R10 held valid", longint'(out_valid), 1);
    check("R10 still not ready", longint'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R10 B after release", longint'(out_col), 25);
    @(negedge clk); check("R10 C after release", longint'(out_col), 96);
    @(negedge clk); check("R10 D after release", longint'(out_col), 128);
    check("R10 D valid", longint'(out_valid), 1);
    @(negedge clk); check("R10 drained", longint'(out_valid), 0);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_data();
    t_ecc();
    t_cross();
    t_marker();
    t_free();
    t_oor();
    t_skip();
    t_pair();
    t_stream();
    t_backpressure();
    finish_up();
  end
endmodule